// File: doc/BRIEF.md
# Packet Buffer Pointer and Data Port

This block gives a host access to an on-chip packet buffer. A 16-bit pointer register holds a byte offset into a packet, a region select (receive or transmit), a transfer direction and an auto-advance enable. A 32-bit data register moves one word at a time between the host and the buffer, at the location the pointer names. The direction of a data access comes from the pointer's direction bit, not from the host strobe.

The data register can be reached in two ways. The first is the decoded register path, which uses a register address. The second is a dedicated data select that ignores the address and always reaches the data register. In synchronous mode, a cycle-frame input asserted together with the data select opens a burst. In a burst, one word moves in every clock where the ready-return input is high. A low ready-return holds the current beat as a wait state. The buffer is a simple internal RAM with one half for each region.

Top module: `pktbuf_port`

## Requirements
- R1: After reset, a pointer read returns 0 in bits 15:0 (with the empty-status input low), and `h_rvalid` is low.
- R2: Pointer layout is bit 15 region (1 = receive), bit 14 auto-advance, bit 13 direction (1 = read buffer), bit 12 reserved, bit 11 not-empty, bits 10:0 byte offset. Bit 12 always reads 0. Bit 11 reads `rx_nempty`. Host writes to bits 12 and 11 are ignored. Bits 31:16 of a pointer read are 0.
- R3: The region bit selects one of two separate buffer halves. The same offset in the two regions holds independent words.
- R4: A data access reads the buffer when the direction bit is 1 and writes it when the bit is 0, whatever `h_we` is. A data write gives no `h_rvalid`.
- R5: With auto-advance set, each data access adds 4 to the offset, wrapping modulo 2048.
- R6: With auto-advance clear, data accesses leave the pointer unchanged, so repeated accesses reach the same word.
- R7: A strobe with `h_dsel` high is a data access whatever `h_addr` is. It never writes the pointer.
- R8: In synchronous mode with `h_cyc` and `h_dsel` high, every clock with `h_rdy` high is one data beat, and `h_req` is ignored.
- R9: In a burst, a clock with `h_rdy` low moves no data, gives no `h_rvalid` and leaves the pointer unchanged.
- R10: With `sync_mode` low, `h_cyc` and `h_rdy` have no effect. Only `h_req` strobes make accesses.
- R11: While a burst is open, decoded accesses are ignored, so a pointer write cannot change the address mid-burst.
- R12: A read (pointer or data) returns its value with `h_rvalid` high exactly one clock after the access. Data register offset is 8, pointer offset is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | Enables bursts on the data-select path |
| rx_nempty | input | 1 | Receive-not-empty status shown in the pointer |
| h_req | input | 1 | One-clock access strobe |
| h_we | input | 1 | Write flag for pointer accesses |
| h_addr | input | 4 | Register byte offset on the decoded path |
| h_dsel | input | 1 | Data select that bypasses decoding |
| h_cyc | input | 1 | Burst frame |
| h_rdy | input | 1 | Ready-return; low inserts a wait state |
| h_wdata | input | 32 | Write data |
| h_rdata | output | 32 | Read data |
| h_rvalid | output | 1 | Read data valid |

## Verification
The assertions assume that inputs are low while reset is held, and that the host never opens a burst while a decoded pointer write is in the same clock. The stimulus changes inputs only on falling edges and keeps them low during reset. The random mix issues single strobes only outside bursts. Bursts are driven by a dedicated task that holds `h_cyc` and `h_dsel` for their whole length.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam int BIT_RGN  = 15;
  localparam int BIT_AINC = 14;
  localparam int BIT_DIR  = 13;
  localparam int BIT_RSV  = 12;
  localparam int BIT_NEMP = 11;
  localparam logic [3:0] OFS_PTR  = 4'd6;
  localparam logic [3:0] OFS_DATA = 4'd8;
  typedef enum logic {ST_IDLE = 1'b0, ST_BURST = 1'b1} burst_st_t;
endpackage

// File: rtl/pbp_ptr_reg.sv
module pbp_ptr_reg #(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [15:0]      wdata,
  input  logic             adv,
  input  logic             nempty_in,
  output logic [15:0]      rdbk,
  output logic             rgn,
  output logic             ainc,
  output logic             rdir,
  output logic [OFF_W-1:0] off
);
  import pbp_pkg::*;
  localparam logic [OFF_W-1:0] STEP = OFF_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      rgn  <= 1'b0;
      ainc <= 1'b0;
      rdir <= 1'b0;
      off  <= '0;
    end else if (wr_en) begin
      rgn  <= wdata[BIT_RGN];
      ainc <= wdata[BIT_AINC];
      rdir <= wdata[BIT_DIR];
      off  <= wdata[OFF_W-1:0];
    end else if (adv && ainc) begin
      off <= off + STEP;
    end
  end

  always_comb begin
    rdbk = '0;
    rdbk[BIT_RGN]    = rgn;
    rdbk[BIT_AINC]   = ainc;
    rdbk[BIT_DIR]    = rdir;
    rdbk[BIT_NEMP]   = nempty_in;
    rdbk[OFF_W-1:0]  = off;
  end

  AST_NOINC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (adv && !ainc && !wr_en) |=> $stable(off)); // R6
endmodule

// File: rtl/pbp_buf_ram.sv
module pbp_buf_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/pbp_burst_ctl.sv
module pbp_burst_ctl #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_mode,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dsel,
  input  logic              cyc,
  input  logic              rdy,
  output logic              burst_act,
  output logic              data_acc,
  output logic              ptr_wr,
  output logic              ptr_rd
);
  import pbp_pkg::*;
  burst_st_t st;
  logic single;

  always_comb begin
    burst_act = sync_mode && cyc && (dsel || st == ST_BURST);
    single    = !burst_act && req;
    data_acc  = (burst_act && dsel && rdy) ||
                (single && (dsel || addr == ADDR_W'(OFS_DATA)));
    ptr_wr    = single && !dsel && addr == ADDR_W'(OFS_PTR) && we;
    ptr_rd    = single && !dsel && addr == ADDR_W'(OFS_PTR) && !we;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= burst_act ? ST_BURST : ST_IDLE;
  end
endmodule

// File: rtl/pktbuf_port.sv
module pktbuf_port #(
  parameter int OFF_W  = 11,
  parameter int DW     = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_mode,
  input  logic              rx_nempty,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_dsel,
  input  logic              h_cyc,
  input  logic              h_rdy,
  input  logic [DW-1:0]     h_wdata,
  output logic [DW-1:0]     h_rdata,
  output logic              h_rvalid
);
  import pbp_pkg::*;
  localparam int RAM_AW = OFF_W - 1;

  logic burst_act, data_acc, ptr_wr, ptr_rd;
  logic [15:0] rdbk;
  logic rgn, ainc, rdir;
  logic [OFF_W-1:0] off;
  logic [DW-1:0] ram_q;
  logic [RAM_AW-1:0] ram_addr;
  logic [15:0] ptr_cap_q;
  logic sel_ptr_q;

  pbp_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .req(h_req), .we(h_we),
    .addr(h_addr), .dsel(h_dsel), .cyc(h_cyc), .rdy(h_rdy),
    .burst_act(burst_act), .data_acc(data_acc), .ptr_wr(ptr_wr), .ptr_rd(ptr_rd)
  );

  pbp_ptr_reg #(.OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst(rst), .wr_en(ptr_wr), .wdata(h_wdata[15:0]), .adv(data_acc),
    .nempty_in(rx_nempty), .rdbk(rdbk), .rgn(rgn), .ainc(ainc), .rdir(rdir), .off(off)
  );

  assign ram_addr = {rgn, off[OFF_W-1:2]};

  pbp_buf_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk(clk), .we(data_acc && !rdir), .addr(ram_addr), .wdata(h_wdata), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rvalid  <= 1'b0;
      sel_ptr_q <= 1'b0;
      ptr_cap_q <= '0;
    end else begin
      h_rvalid  <= (data_acc && rdir) || ptr_rd;
      sel_ptr_q <= ptr_rd;
      if (ptr_rd) ptr_cap_q <= rdbk;
    end
  end

  assign h_rdata = sel_ptr_q ? {{(DW-16){1'b0}}, ptr_cap_q} : ram_q;

  AST_AINC_STEP: assert property (@(posedge clk) disable iff (rst)
    (data_acc && ainc) |=> off == OFF_W'($past(off) + OFF_W'(4))); // R5
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (burst_act && !h_rdy) |=> ($stable(off) && !h_rvalid)); // R9
  AST_PTR_WR_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (burst_act && h_req && !h_dsel && h_we && h_addr == ADDR_W'(OFS_PTR))
    |=> ($stable(rgn) && $stable(rdir))); // R11
  AST_ASYNC_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && !h_req) |=> (!h_rvalid && $stable(off))); // R10
  AST_DSEL_NO_PTR_WR: assert property (@(posedge clk) disable iff (rst)
    (h_req && h_dsel && !burst_act) |=> ($stable(rgn) && $stable(ainc))); // R7
endmodule

// File: tb/tb_pktbuf_port.sv
module tb_pktbuf_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, sync_mode = 0, rx_nempty = 0;
  logic h_req = 0, h_we = 0, h_dsel = 0, h_cyc = 0, h_rdy = 0;
  logic [3:0] h_addr = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic h_rvalid;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [1024];
  logic m_rgn, m_ainc, m_dir;
  logic [10:0] m_off;

  always #(CLK_PERIOD/2) clk = ~clk;

  pktbuf_port dut (.*);

  function automatic logic [15:0] exp_ptr();
    return {m_rgn, m_ainc, m_dir, 1'b0, rx_nempty, m_off};
  endfunction
  function automatic int widx();
    return {m_rgn, m_off[10:2]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    h_req = 0; h_we = 0; h_dsel = 0; h_cyc = 0; h_rdy = 0; h_addr = 0;
  endtask

  task automatic ptr_write(input logic [15:0] v);
    @(negedge clk);
    h_req = 1; h_we = 1; h_dsel = 0; h_addr = 4'd6; h_wdata = {$urandom, v} ;
    h_wdata[15:0] = v;
    @(negedge clk);
    idle_inputs();
    m_rgn = v[15]; m_ainc = v[14]; m_dir = v[13]; m_off = v[10:0];
  endtask

  task automatic ptr_check(input string req);
    @(negedge clk);
    h_req = 1; h_we = 0; h_dsel = 0; h_addr = 4'd6;
    @(negedge clk);
    idle_inputs();
    chk(h_rvalid && h_rdata == {16'h0, exp_ptr()}, req, h_rdata, {16'h0, exp_ptr()});
  endtask

  // single data access; use_dsel picks the bypass path with a junk address
  task automatic data_single(input bit use_dsel, input logic [31:0] d, input string req);
    int idx;
    idx = widx();
    @(negedge clk);
    h_req = 1; h_we = $urandom; h_wdata = d;
    if (use_dsel) begin h_dsel = 1; h_addr = 4'($urandom); end
    else begin h_dsel = 0; h_addr = 4'd8; end
    @(negedge clk);
    idle_inputs();
    if (m_dir) chk(h_rvalid && h_rdata == mem[idx], req, h_rdata, mem[idx]);
    else begin
      chk(!h_rvalid, req, 32'(h_rvalid), 0);
      mem[idx] = d;
    end
    if (m_ainc) m_off = m_off + 11'd4;
  endtask

  // burst of nb beats with random wait states; h_req toggles randomly (ignored)
  task automatic burst(input int nb, input bit fixed_data, input string req);
    int beats = 0;
    int idx;
    @(negedge clk);
    sync_mode = 1; h_dsel = 1; h_cyc = 1;
    while (beats < nb) begin
      h_rdy = ($urandom % 3) != 0;
      h_req = $urandom;
      h_addr = 4'($urandom);
      h_wdata = fixed_data ? 32'h1000_0000 + 32'(widx()) * 32'h0001_0003 : $urandom;
      idx = widx();
      @(negedge clk);
      if (h_rdy) begin
        beats++;
        if (m_dir) chk(h_rvalid && h_rdata == mem[idx], req, h_rdata, mem[idx]);
        else begin
          if (!fixed_data) chk(!h_rvalid, req, 32'(h_rvalid), 0);
          mem[idx] = h_wdata;
        end
        if (m_ainc) m_off = m_off + 11'd4;
      end else begin
        chk(!h_rvalid, "R9", 32'(h_rvalid), 0);
      end
    end
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_rgn = 0; m_ainc = 0; m_dir = 0; m_off = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!h_rvalid, "R1", 32'(h_rvalid), 0);
    ptr_check("R1");

    // fill both regions with bursts (R8, R3)
    ptr_write(16'h4000);
    burst(512, 1'b1, "R8");
    ptr_write(16'hC000);
    burst(512, 1'b1, "R8");
    chk(m_off == 0, "R5", 32'(m_off), 0);
    ptr_check("R5");

    // R3: same offset, different regions
    ptr_write(16'h2010);
    data_single(0, 0, "R3");
    ptr_write(16'hA010);
    data_single(0, 0, "R3");

    // R2: reserved and not-empty writes ignored, nempty shows input
    rx_nempty = 1;
    ptr_write(16'h1800 | 16'h0123);
    ptr_check("R2");
    rx_nempty = 0;
    ptr_check("R2");

    // R4: direction from pointer bit, h_we random; write then read back
    ptr_write(16'h0040);
    data_single(0, 32'hDEAD_BEEF, "R4");
    ptr_write(16'h2040);
    data_single(0, 0, "R4");

    // R6: no auto-advance, repeated access same word
    data_single(1, 0, "R6");
    data_single(0, 0, "R6");
    ptr_check("R6");

    // R5: wrap at top of offset
    ptr_write(16'h47FC);
    data_single(0, 32'h0BAD_CAFE, "R5");
    ptr_check("R5");

    // R7: dsel with pointer address is a data write, pointer not overwritten
    ptr_write(16'h4100);
    @(negedge clk);
    h_req = 1; h_dsel = 1; h_addr = 4'd6; h_we = 1; h_wdata = 32'h0000_E7FF;
    @(negedge clk);
    idle_inputs();
    mem[widx()] = 32'h0000_E7FF;
    m_off = m_off + 11'd4;
    ptr_check("R7");
    ptr_write(16'h2100);
    data_single(0, 0, "R7");

    // R11: pointer write refused inside an open burst
    ptr_write(16'h6200);
    @(negedge clk);
    sync_mode = 1; h_cyc = 1; h_dsel = 1; h_rdy = 0;
    @(negedge clk);
    h_dsel = 0; h_req = 1; h_we = 1; h_addr = 4'd6; h_wdata = 32'h0000_8004;
    @(negedge clk);
    idle_inputs();
    ptr_check("R11");

    // R10: async mode ignores cyc/rdy
    sync_mode = 0;
    ptr_write(16'h6300);
    @(negedge clk);
    h_cyc = 1; h_dsel = 1; h_rdy = 1;
    repeat (3) begin
      @(negedge clk);
      chk(!h_rvalid, "R10", 32'(h_rvalid), 0);
    end
    idle_inputs();
    ptr_check("R10");
    data_single(1, 0, "R10");

    // read bursts with wait states (R8, R9, R12)
    ptr_write(16'h6000);
    burst(40, 1'b0, "R12");
    ptr_write(16'hE3F0);
    burst(30, 1'b0, "R8");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 6;
      rx_nempty = $urandom;
      sync_mode = $urandom;
      case (op)
        0: ptr_write(16'($urandom));
        1: ptr_check("R2");
        2, 3: data_single(op == 2, $urandom, "R4");
        4: if (sync_mode) burst(1 + $urandom % 6, 1'b0, "R8");
           else data_single(1, $urandom, "R10");
        default: data_single(0, $urandom, "R12");
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule